// File: doc/BRIEF.md
# Coincidence Window Controller

This block sits at the centre of a multi-node acquisition system. Every detector node drives a single event line toward it whenever that node registers a hit. The controller brings each line into its own clock domain and finds the rising edge. It then opens a short per-node window of programmable length and watches for an overlap with the window of another node. Overlap alone is not enough: the two nodes must also form a pair that a geometric permission matrix allows. Each node that took part in a qualifying overlap gets a one-cycle accept pulse back on its own line when its window expires. A strobe that never met a permitted partner expires without a pulse.

The controller also owns system run control. A start command enables acquisition and releases the node-wide reset. It also emits a one-cycle timer synchronisation pulse so that every node clears its time-stamp counter on the same edge. A stop command disables acquisition, holds the nodes in reset and discards every open window. Both commands are synchronous one-cycle inputs from the system's command path.

Top module: `coinc_ctrl`

## Requirements
- R1: After reset, run_o is 0, node_reset_o is 1, accept_o is all zero and tsync_o is 0.
- R2: A start command sets run_o to 1 and clears node_reset_o on the next clock edge, and raises tsync_o for exactly that one cycle. A start while already running repeats the tsync_o pulse and leaves run_o at 1.
- R3: A stop command clears run_o and sets node_reset_o on the next clock edge. When start and stop arrive in the same cycle, stop wins and no tsync_o pulse is issued.
- R4: Each strobe passes through two synchroniser flops and a rising-edge detector. A window of length W opens on the third clock edge after the strobe is first sampled high. When such a window qualifies, the node's accept pulse appears on the (W+2)th clock edge after that first sampling edge.
- R5: Two permitted nodes both receive accept when their detected rising edges are fewer than W cycles apart. At a separation of W cycles or more, neither node receives accept.
- R6: Bit i*N+j of pair_mask_i permits the pair of nodes i and j. A pair counts as permitted when either bit i*N+j or bit j*N+i is set. Diagonal bits are ignored. A node whose only overlapping partner is not permitted receives no accept, even when a permitted pair is accepted in the same cycle.
- R7: A strobe with no partner inside its window expires with no accept.
- R8: A new rising edge from a node whose window is still open restarts that window at full length W. A partner seen before the restart still counts.
- R9: accept_o for a node is a single-cycle pulse, issued once per window at the window's close.
- R10: Strobes arriving while run_o is 0 open no window and produce no accept, including after a later start.
- R11: A stop discards every open window. An accept that would have been issued on the same edge as the stop is suppressed.
- R12: win_len_i holds W in clock cycles, from 1 to 15. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_strobe_i | input | N_NODES | Per-node event lines, asynchronous to clk |
| win_len_i | input | WIN_BITS | Coincidence window length W in clock cycles |
| pair_mask_i | input | N_NODES*N_NODES | Pair permission matrix, bit i*N+j for nodes i and j |
| start_cmd_i | input | 1 | Synchronous start command |
| stop_cmd_i | input | 1 | Synchronous stop command |
| accept_o | output | N_NODES | Per-node one-cycle accept pulses |
| run_o | output | 1 | Acquisition enabled |
| node_reset_o | output | 1 | Holds every node in reset while acquisition is stopped |
| tsync_o | output | 1 | One-cycle pulse that clears every node's time-stamp counter |

## Verification
A stop command and the close of a qualifying window can land on the same clock edge. If this case is handled wrongly, an accept leaks out after run has dropped. The bench provokes it by sending a permitted pair and issuing stop in the cycle just before the pair's known close edge. It then expects no accept on either node, with run_o low and node_reset_o high afterwards. Start and stop in the same cycle form a second collision, and the bench judges it by the absence of a tsync_o pulse and a low run_o.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  typedef enum logic [1:0] {
    RUN_IDLE   = 2'b00,
    RUN_ACTIVE = 2'b01
  } run_state_e;

  // window length actually loaded: zero is raised to one cycle
  function automatic int clamp_len(input int raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // a pair is permitted when either triangle of the matrix says so
  function automatic logic pair_permitted(input logic b_ij, input logic b_ji,
                                          input int i, input int j);
    return (i != j) && (b_ij || b_ji);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q && !s3_q;
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o,
  output logic tsync_o,
  output logic clear_o,
  output logic open_en_o
);
  import coinc_pkg::*;

  run_state_e state_q;
  logic       tsync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      tsync_q <= 1'b0;
    end else begin
      tsync_q <= start_i && !stop_i;
      if (stop_i)       state_q <= RUN_IDLE;
      else if (start_i) state_q <= RUN_ACTIVE;
    end
  end

  assign run_o     = (state_q == RUN_ACTIVE);
  assign tsync_o   = tsync_q;
  assign clear_o   = !run_o || stop_i;
  assign open_en_o = run_o && !stop_i;
endmodule

// File: rtl/win_tracker.sv
module win_tracker #(
  parameter int WIN_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                rise_i,
  input  logic [WIN_BITS-1:0] len_i,
  input  logic                partner_i,
  output logic                active_o,
  output logic                accept_o
);
  import coinc_pkg::*;

  logic [WIN_BITS-1:0] cnt_q, len_eff;
  logic                hit_q, acc_q, hit_now, closing;

  assign len_eff  = WIN_BITS'(clamp_len(int'(len_i)));
  assign active_o = (cnt_q != '0);
  assign closing  = (cnt_q == WIN_BITS'(1)) && !rise_i;
  assign hit_now  = active_o && partner_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
      acc_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      acc_q <= closing && (hit_q || hit_now);
      if (rise_i)               cnt_q <= len_eff;
      else if (cnt_q != '0)     cnt_q <= cnt_q - WIN_BITS'(1);
      if (closing)              hit_q <= 1'b0;
      else if (hit_now)         hit_q <= 1'b1;
    end
  end

  assign accept_o = acc_q;
endmodule

// File: rtl/coinc_ctrl.sv
module coinc_ctrl #(
  parameter int N_NODES  = 4,
  parameter int WIN_BITS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_NODES-1:0]           node_strobe_i,
  input  logic [WIN_BITS-1:0]          win_len_i,
  input  logic [N_NODES*N_NODES-1:0]   pair_mask_i,
  input  logic                         start_cmd_i,
  input  logic                         stop_cmd_i,
  output logic [N_NODES-1:0]           accept_o,
  output logic                         run_o,
  output logic                         node_reset_o,
  output logic                         tsync_o
);
  logic [N_NODES-1:0] rise, win_open, partner;
  logic               clear_all, open_en;

  run_ctrl u_run (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_cmd_i), .stop_i(stop_cmd_i),
    .run_o(run_o), .tsync_o(tsync_o),
    .clear_o(clear_all), .open_en_o(open_en)
  );

  assign node_reset_o = !run_o;

  for (genvar i = 0; i < N_NODES; i++) begin : g_node
    logic [N_NODES-1:0] allow_row;

    for (genvar j = 0; j < N_NODES; j++) begin : g_pair
      assign allow_row[j] = coinc_pkg::pair_permitted(
        pair_mask_i[i*N_NODES+j], pair_mask_i[j*N_NODES+i], i, j);
    end

    assign partner[i] = |(win_open & allow_row);

    strobe_sync u_sync (
      .clk(clk), .rst_n(rst_n),
      .async_i(node_strobe_i[i]), .rise_o(rise[i])
    );

    win_tracker #(.WIN_BITS(WIN_BITS)) u_win (
      .clk(clk), .rst_n(rst_n),
      .clear_i(clear_all),
      .rise_i(rise[i] && open_en),
      .len_i(win_len_i),
      .partner_i(partner[i]),
      .active_o(win_open[i]),
      .accept_o(accept_o[i])
    );
  end
endmodule

// File: rtl/coinc_chk.sv
module coinc_chk #(
  parameter int N_NODES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_cmd_i,
  input logic               stop_cmd_i,
  input logic [N_NODES-1:0] accept_o,
  input logic               run_o,
  input logic               tsync_o,
  input logic [N_NODES-1:0] win_open
);
  // R9
  accept_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o & $past(accept_o)) == '0);

  // R11
  accept_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o != '0) |-> run_o);

  // R2
  tsync_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tsync_o |-> ($past(start_cmd_i) && !$past(stop_cmd_i) && run_o));

  // R3
  stop_drops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_cmd_i) |-> (!run_o && accept_o == '0 && !tsync_o));

  // R10
  window_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open != '0) |-> run_o);
endmodule

bind coinc_ctrl coinc_chk #(.N_NODES(N_NODES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .start_cmd_i(start_cmd_i), .stop_cmd_i(stop_cmd_i),
  .accept_o(accept_o), .run_o(run_o), .tsync_o(tsync_o),
  .win_open(win_open)
);

// File: tb/sim_coinc_ctrl.sv
module sim_coinc_ctrl;
  localparam int N = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] strobe;
  logic [3:0]   win_len;
  logic [15:0]  mask;
  logic         start_cmd, stop_cmd;
  logic [N-1:0] accept;
  logic         run, node_rst, tsync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  coinc_ctrl #(.N_NODES(N), .WIN_BITS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .node_strobe_i(strobe), .win_len_i(win_len),
    .pair_mask_i(mask), .start_cmd_i(start_cmd), .stop_cmd_i(stop_cmd),
    .accept_o(accept), .run_o(run), .node_reset_o(node_rst), .tsync_o(tsync)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive a command for one cycle, sample after the edge that takes it
  task automatic cmd(logic s, logic p);
    start_cmd = s;
    stop_cmd  = p;
    @(posedge clk); @(negedge clk);
    start_cmd = 1'b0;
    stop_cmd  = 1'b0;
  endtask

  // strobe schedule: up to three (cycle, mask) events; e* = expected accept cycle, -1 none
  task automatic run_case(string req, int ta, logic [3:0] ma, int tb2, logic [3:0] mb,
                          int tc, logic [3:0] mc, int stop_at,
                          int e0, int e1, int e2, int e3);
    int first[N];
    int cnt[N];
    int ex[N];
    ex = '{e0, e1, e2, e3};
    for (int i = 0; i < N; i++) begin first[i] = -1; cnt[i] = 0; end
    for (int c = 0; c < 40; c++) begin
      logic [3:0] s;
      s = '0;
      if (c == ta)  s = s | ma;
      if (c == tb2) s = s | mb;
      if (c == tc)  s = s | mc;
      strobe   = s;
      stop_cmd = (c == stop_at);
      for (int i = 0; i < N; i++)
        if (accept[i]) begin
          cnt[i]++;
          if (first[i] < 0) first[i] = c;
        end
      @(posedge clk); @(negedge clk);
    end
    strobe   = '0;
    stop_cmd = 1'b0;
    for (int i = 0; i < N; i++) begin
      chk(req, $sformatf("node%0d accept count", i), cnt[i], (ex[i] >= 0) ? 1 : 0);
      if (ex[i] >= 0) chk(req, $sformatf("node%0d accept cycle", i), first[i], ex[i]);
    end
  endtask

  task automatic t_reset();
    // R1
    chk("R1", "run_o", run, 0);
    chk("R1", "node_reset_o", node_rst, 1);
    chk("R1", "accept_o", accept, 0);
    chk("R1", "tsync_o", tsync, 0);
  endtask

  task automatic t_start();
    // R2
    start_cmd = 1'b1;
    @(posedge clk); @(negedge clk);
    start_cmd = 1'b0;
    chk("R2", "run_o after start", run, 1);
    chk("R2", "node_reset_o after start", node_rst, 0);
    chk("R2", "tsync_o pulse", tsync, 1);
    @(posedge clk); @(negedge clk);
    chk("R2", "tsync_o one cycle", tsync, 0);
  endtask

  task automatic t_stop_start_same();
    // R3: stop wins over a simultaneous start
    cmd(1'b1, 1'b1);
    chk("R3", "run_o after start+stop", run, 0);
    chk("R3", "node_reset_o after start+stop", node_rst, 1);
    chk("R3", "tsync_o after start+stop", tsync, 0);
  endtask

  task automatic t_restart_running();
    // R2: start while running repeats the sync pulse
    cmd(1'b1, 1'b0);
    chk("R2", "repeat start tsync_o", tsync, 1);
    chk("R2", "repeat start run_o", run, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strobe = '0; win_len = 4'd4; mask = 16'h4002;
    start_cmd = 1'b0; stop_cmd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_start();

    // R4 R5: permitted pair (0,1) at the same time, W=4 -> accept at cycle 7
    run_case("R4", 0, 4'b0011, -1, 4'b0, -1, 4'b0, -1, 7, 7, -1, -1);
    // R5 R6: pair (2,3) permitted only by bit 14, 3 cycles apart
    run_case("R6", 0, 4'b0100, 3, 4'b1000, -1, 4'b0, -1, -1, -1, 7, 10);
    // R5: separation equal to W gives no coincidence
    run_case("R5", 0, 4'b0001, 4, 4'b0010, -1, 4'b0, -1, -1, -1, -1, -1);
    // R6: pair (0,2) not permitted
    run_case("R6", 0, 4'b0101, -1, 4'b0, -1, 4'b0, -1, -1, -1, -1, -1);
    // R7: lone strobe
    run_case("R7", 0, 4'b1000, -1, 4'b0, -1, 4'b0, -1, -1, -1, -1, -1);
    // R6: node 2 overlaps but has no permitted partner
    run_case("R6", 0, 4'b0111, -1, 4'b0, -1, 4'b0, -1, 7, 7, -1, -1);
    // R8 R9: node 0 restarts at 2 and then meets node 1 at 5
    run_case("R8", 0, 4'b0001, 2, 4'b0001, 5, 4'b0010, -1, 9, 12, -1, -1);

    // R11: stop on the same edge as the pair's close
    run_case("R11", 0, 4'b0011, -1, 4'b0, -1, 4'b0, 6, -1, -1, -1, -1);
    chk("R11", "run_o after stop", run, 0);
    chk("R3", "node_reset_o after stop", node_rst, 1);

    // R10: strobes while stopped, then start and watch for stale accepts
    run_case("R10", 0, 4'b0011, -1, 4'b0, -1, 4'b0, -1, -1, -1, -1, -1);
    t_start();
    run_case("R10", -1, 4'b0, -1, 4'b0, -1, 4'b0, -1, -1, -1, -1, -1);

    t_restart_running();
    t_stop_start_same();
    t_start();

    // R12: window length 0 acts as 1
    win_len = 4'd0;
    run_case("R12", 0, 4'b0011, -1, 4'b0, -1, 4'b0, -1, 4, 4, -1, -1);
    run_case("R12", 0, 4'b0001, 1, 4'b0010, -1, 4'b0, -1, -1, -1, -1, -1);

    // R5: widest window, separation W-1
    win_len = 4'd15;
    run_case("R5", 0, 4'b0001, 14, 4'b0010, -1, 4'b0, -1, 18, 32, -1, -1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule